// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one channel of a memory-mapped interval timer. A 32-bit down-counter is decremented by a tick from a free-running prescaler that divides the peripheral clock by 4, 16, 64, 256 or 1024. When a tick arrives with the counter already at zero, the counter reloads from a reload register and sets a sticky underflow flag. The flag is ANDed with an interrupt-enable bit to drive the interrupt line.

Software reaches the channel through a small word-addressed register port with a one-cycle write strobe, a read strobe and a combinational read bus. The port holds a reload register, the live counter, a control register and, when the channel is built with the capture feature, a plain 32-bit storage register. An external run input starts and stops counting. Writes of illegal control encodings, and accesses to unmapped offsets, raise a one-cycle error pulse. Illegal control fields are stored as zero.

Top module: `itc_channel`

## Requirements
- R1: After reset the reload register and the counter both read 0xFFFFFFFF, the control register reads 0, the capture register reads 0, and the interrupt and error outputs are low.
- R2: Byte offsets 0x0, 0x4, 0x8 and 0xC select the reload, counter, control and capture registers. A read or write at a misaligned offset, or at 0xC on a channel without capture, returns 0 on reads, changes nothing, and pulses the error output.
- R3: Control bits [2:0] select the prescale: code 0 divides by 4, 1 by 16, 2 by 64, 3 by 256 and 4 by 1024. A control write restarts the prescaler phase, so with run held high from the cycle after that write the counter drops by one after exactly the divide ratio in cycles and not before.
- R4: While the run input is low the counter holds its value.
- R5: A tick with the counter at zero reloads the counter from the reload register and sets the underflow flag. Writing the reload register only changes the next reload value. Writing the counter register loads it directly.
- R6: A control write with bit 8 = 0 clears the underflow flag. A write with bit 8 = 1 leaves the flag unchanged. A control read returns the current flag in bit 8.
- R7: The interrupt output is high exactly when the underflow flag and control bit 5 (interrupt enable) are both set. It follows a control write or an underflow in the next cycle.
- R8: Reserved control content is rejected: bits [31:10], prescale code 5, codes 6 and 7 without the external-clock option, a nonzero edge field [4:3] without that option, capture-enable [7:6] value 1, or any capture field without the capture option. Such a write pulses the error output and stores each offending field as 0. Bit 9 is never stored, and it is legal on a capture channel.
- R9: The error output is a single-cycle pulse, one cycle after the offending access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start/stop gate for counting |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Underflow interrupt |
| err_o | output | 1 | One-cycle illegal-access pulse |

## Verification
The bench stops the clock gate exactly one cycle before each divide ratio elapses and confirms that the counter has not moved. It then repeats the run for the full ratio and confirms a single decrement. A prescaler that was off by one, or that was not restarted by a control write, fails one of these two reads. Underflow is forced from a small count to show both the reload value and the flag. Writes with bit 8 set and with bit 8 cleared separate a flag that is wrongly cleared by written ones from one that is never cleared. Writes with reserved fields, misaligned offsets and back-to-back error checks catch fields that are stored instead of masked and error pulses that stretch past one cycle.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int DATA_W  = 32;
    localparam int CTRL_W  = 16;
    localparam int ADDR_W  = 4;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_CAPT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       cap_flag;
        logic       unf;
        logic [1:0] cap_en;
        logic       unie;
        logic [1:0] edge_sel;
        logic [2:0] psc;
    } ctrl_t;

    typedef struct packed {
        ctrl_t val;
        logic  bad;
    } ctrl_chk_t;

    // Filters a control write: illegal fields become zero, bad marks the write.
    function automatic ctrl_chk_t ctrl_clean(input logic [DATA_W-1:0] w,
                                             input logic has_capt,
                                             input logic has_ext);
        ctrl_chk_t r;
        ctrl_t     raw;
        logic      psc_bad;
        logic      edge_bad;
        logic      cap_bad;
        raw      = ctrl_t'(w[CTRL_W-1:0]);
        psc_bad  = (raw.psc == 3'd5) || (raw.psc[2:1] == 2'b11 && !has_ext);
        edge_bad = (raw.edge_sel != 2'd0) && !has_ext;
        cap_bad  = (raw.cap_en == 2'd1) || (raw.cap_en != 2'd0 && !has_capt);
        r.val          = raw;
        r.val.psc      = psc_bad  ? 3'd0 : raw.psc;
        r.val.edge_sel = edge_bad ? 2'd0 : raw.edge_sel;
        r.val.cap_en   = cap_bad  ? 2'd0 : raw.cap_en;
        r.val.cap_flag = 1'b0;
        r.val.unf      = 1'b0;
        r.val.rsvd     = '0;
        r.bad = psc_bad || edge_bad || cap_bad
              || (raw.cap_flag && !has_capt)
              || (raw.rsvd != '0)
              || (w[DATA_W-1:CTRL_W] != '0);
        return r;
    endfunction

endpackage

// File: rtl/itc_prescaler.sv
module itc_prescaler #(
    parameter int N_CODES = 5
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       restart_i,
    input  logic [2:0] code_i,
    output logic       tick_o
);
    localparam int DIV_W = 2 * N_CODES;

    logic [DIV_W-1:0]   div_q;
    logic [N_CODES-1:0] tick_vec;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    // Code k ticks once every 4^(k+1) cycles.
    for (genvar k = 0; k < N_CODES; k++) begin : g_tap
        assign tick_vec[k] = &div_q[2*k+1:0];
    end

    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_CODES; i++) begin
            if (code_i == 3'(i)) tick_o = tick_vec[i];
        end
    end

endmodule

// File: rtl/itc_counter.sv
module itc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             ld_cnt_i,
    input  logic             ld_reload_i,
    input  logic             clr_flag_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             flag_o
);
    logic step;
    logic underflow;

    assign step      = tick_i && run_i;
    assign underflow = step && (cnt_o == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o    <= '1;
            reload_o <= '1;
            flag_o   <= 1'b0;
        end else begin
            if (ld_reload_i) reload_o <= wdata_i;
            if (ld_cnt_i)               cnt_o <= wdata_i;
            else if (underflow)         cnt_o <= reload_o;
            else if (step)              cnt_o <= cnt_o - 1'b1;
            if (underflow && !ld_cnt_i) flag_o <= 1'b1;
            else if (clr_flag_i)        flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/itc_csr.sv
module itc_csr
    import itc_pkg::*;
#(
    parameter bit HAS_CAPT   = 1'b1,
    parameter bit HAS_EXTCLK = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              flag_i,
    output logic              ld_reload_o,
    output logic              ld_cnt_o,
    output logic              ctrl_wr_o,
    output logic              clr_flag_o,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);
    reg_sel_e          sel;
    logic              hit;
    logic              wr_ok;
    ctrl_chk_t         cc;
    ctrl_t             ctrl_rd;
    logic [DATA_W-1:0] capt_q;

    assign sel   = reg_sel_e'(addr_i[3:2]);
    assign hit   = (addr_i[1:0] == 2'b00) && (sel != SEL_CAPT || HAS_CAPT);
    assign wr_ok = wr_en_i && hit;
    assign cc    = ctrl_clean(wdata_i, HAS_CAPT, HAS_EXTCLK);

    assign ld_reload_o = wr_ok && (sel == SEL_RELOAD);
    assign ld_cnt_o    = wr_ok && (sel == SEL_COUNT);
    assign ctrl_wr_o   = wr_ok && (sel == SEL_CTRL);
    assign clr_flag_o  = ctrl_wr_o && !wdata_i[8];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_o <= '0;
            capt_q <= '0;
            err_o  <= 1'b0;
        end else begin
            if (ctrl_wr_o) ctrl_o <= cc.val;
            if (wr_ok && sel == SEL_CAPT) capt_q <= wdata_i;
            err_o <= ((wr_en_i || rd_en_i) && !hit) || (ctrl_wr_o && cc.bad);
        end
    end

    always_comb begin
        ctrl_rd     = ctrl_o;
        ctrl_rd.unf = flag_i;
        rdata_o     = '0;
        if (hit) begin
            unique case (sel)
                SEL_RELOAD: rdata_o = reload_i;
                SEL_COUNT:  rdata_o = cnt_i;
                SEL_CTRL:   rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_rd};
                SEL_CAPT:   rdata_o = capt_q;
                default:    rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/itc_channel.sv
module itc_channel
    import itc_pkg::*;
#(
    parameter bit HAS_CAPT    = 1'b1,
    parameter bit HAS_EXTCLK  = 1'b0,
    parameter int N_PSC_CODES = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              err_o
);
    logic              tick;
    logic              ld_reload;
    logic              ld_cnt;
    logic              ctrl_wr;
    logic              clr_flag;
    logic              flag_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;
    ctrl_t             ctrl_q;

    itc_prescaler #(.N_CODES(N_PSC_CODES)) psc_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (ctrl_wr),
        .code_i    (ctrl_q.psc),
        .tick_o    (tick)
    );

    itc_counter #(.CNT_W(DATA_W)) cnt_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick),
        .run_i       (run_i),
        .ld_cnt_i    (ld_cnt),
        .ld_reload_i (ld_reload),
        .clr_flag_i  (clr_flag),
        .wdata_i     (wdata_i),
        .cnt_o       (cnt_q),
        .reload_o    (reload_q),
        .flag_o      (flag_q)
    );

    itc_csr #(.HAS_CAPT(HAS_CAPT), .HAS_EXTCLK(HAS_EXTCLK)) csr_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .cnt_i       (cnt_q),
        .reload_i    (reload_q),
        .flag_i      (flag_q),
        .ld_reload_o (ld_reload),
        .ld_cnt_o    (ld_cnt),
        .ctrl_wr_o   (ctrl_wr),
        .clr_flag_o  (clr_flag),
        .ctrl_o      (ctrl_q),
        .rdata_o     (rdata_o),
        .err_o       (err_o)
    );

    assign irq_o = flag_q && ctrl_q.unie;

endmodule

// File: rtl/itc_channel_chk.sv
module itc_channel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             run_i,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic             tick,
    input logic             flag_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             irq_o,
    input logic             err_o
);
    // R3: one decrement per tick while running
    p_step_down_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && tick && cnt_q != '0 && !wr_en_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: stopped counter holds
    p_hold_stopped_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_i && !wr_en_i) |=> $stable(cnt_q));

    // R5: underflow reloads and raises the flag
    p_reload_on_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && tick && cnt_q == '0 && !wr_en_i) |=> (cnt_q == $past(reload_q) && flag_q));

    // R6: only a write can lower the flag
    p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_q && !wr_en_i) |=> flag_q);

    // R7: interrupt requires the flag
    p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> flag_q);

    // R9: an error pulse follows an access
    p_err_after_access_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> $past(wr_en_i || rd_en_i));

endmodule

bind itc_channel itc_channel_chk #(.CNT_W(itc_pkg::DATA_W)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (run_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .tick     (tick),
    .flag_q   (flag_q),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .irq_o    (irq_o),
    .err_o    (err_o)
);

// File: tb/itc_channel_tb_top.sv
module itc_channel_tb_top;

    localparam logic [3:0] A_RELOAD = 4'h0;
    localparam logic [3:0] A_COUNT  = 4'h4;
    localparam logic [3:0] A_CTRL   = 4'h8;
    localparam logic [3:0] A_CAPT   = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 err
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    itc_channel dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .run_i   (run),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq),
        .err_o   (err)
    );

    // Monitor: pops one expected item per cycle and compares it.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, err};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        sb_q.push_back('{0, e, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        sb_q.push_back('{1, {31'b0, e}, tag});
        @(negedge clk);
    endtask

    task automatic chk_err(input logic e, input string tag);
        sb_q.push_back('{2, {31'b0, e}, tag});
        @(negedge clk);
    endtask

    // Checks that code c takes exactly n cycles per decrement.
    task automatic ratio(input logic [2:0] c, input int n);
        wr(A_COUNT, 32'd3);
        wr(A_CTRL, {29'b0, c});
        run = 1'b1;
        repeat (n - 1) @(negedge clk);
        run = 1'b0;
        rd(A_COUNT, 32'd3, $sformatf("R3 code %0d no step before %0d cycles", c, n));
        wr(A_CTRL, {29'b0, c});
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
        rd(A_COUNT, 32'd2, $sformatf("R3 code %0d one step after %0d cycles", c, n));
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_RELOAD, 32'hFFFF_FFFF, "R1 reload after reset");
        rd(A_COUNT,  32'hFFFF_FFFF, "R1 counter after reset");
        rd(A_CTRL,   32'h0,         "R1 control after reset");
        rd(A_CAPT,   32'h0,         "R1 capture after reset");
        chk_irq(1'b0, "R1 irq after reset");
        chk_err(1'b0, "R1 err after reset");

        // R2 map and bad offsets
        wr(A_CAPT, 32'hA5A5_1234);
        rd(A_CAPT, 32'hA5A5_1234, "R2 capture storage");
        rd(4'h1, 32'h0, "R2 misaligned read data");
        chk_err(1'b1, "R2 misaligned read error");
        chk_err(1'b0, "R9 error is one cycle");
        wr(4'h6, 32'h1111_1111);
        chk_err(1'b1, "R2 misaligned write error");
        rd(A_COUNT, 32'hFFFF_FFFF, "R2 misaligned write ignored");

        // R4 stopped counter holds
        wr(A_CTRL, 32'h0);
        repeat (40) @(negedge clk);
        rd(A_COUNT, 32'hFFFF_FFFF, "R4 stopped counter holds");

        // R3 prescale ratios
        ratio(3'd0, 4);
        ratio(3'd1, 16);
        ratio(3'd2, 64);
        ratio(3'd3, 256);
        ratio(3'd4, 1024);

        // R5 underflow and reload, R7 interrupt
        wr(A_RELOAD, 32'd5);
        rd(A_RELOAD, 32'd5, "R5 reload register write");
        wr(A_COUNT, 32'd1);
        wr(A_CTRL, 32'h0000_0020);
        run = 1'b1;
        repeat (8) @(negedge clk);
        run = 1'b0;
        rd(A_COUNT, 32'd5, "R5 counter reloaded after zero");
        rd(A_CTRL, 32'h0000_0120, "R6 flag visible in bit 8");
        chk_irq(1'b1, "R7 irq with flag and enable");

        // R6 flag write semantics
        wr(A_CTRL, 32'h0000_0120);
        rd(A_CTRL, 32'h0000_0120, "R6 writing 1 keeps flag");
        wr(A_CTRL, 32'h0000_0100);
        chk_irq(1'b0, "R7 irq low with enable off");
        rd(A_CTRL, 32'h0000_0100, "R6 flag kept, enable off");
        wr(A_CTRL, 32'h0000_0020);
        rd(A_CTRL, 32'h0000_0020, "R6 writing 0 clears flag");
        chk_irq(1'b0, "R7 irq low after clear");

        // R8 reserved content
        wr(A_CTRL, 32'h0000_0405);
        chk_err(1'b1, "R8 reserved bit and code 5 error");
        chk_err(1'b0, "R9 error drops after one cycle");
        rd(A_CTRL, 32'h0, "R8 reserved fields stored as zero");
        wr(A_CTRL, 32'h0000_0078);
        chk_err(1'b1, "R8 edge field and capture enable 1 error");
        rd(A_CTRL, 32'h0000_0020, "R8 edge and capture enable masked");
        wr(A_CTRL, 32'h0000_00A0);
        chk_err(1'b0, "R8 legal capture enable no error");
        rd(A_CTRL, 32'h0000_00A0, "R8 legal capture enable stored");
        wr(A_CTRL, 32'h0000_0206);
        chk_err(1'b1, "R8 external clock code error");
        rd(A_CTRL, 32'h0, "R8 bit 9 and code 6 not stored");
        wr(A_CTRL, 32'h0000_0200);
        chk_err(1'b0, "R8 bit 9 legal on capture channel");
        wr(A_CTRL, 32'h0001_0000);
        chk_err(1'b1, "R8 upper bits error");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule